// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a byte-addressed serial EEPROM. Its storage is an internal register array. SCL and SDA are oversampled on the system clock, so the block needs no clock of its own from the bus. The block drives SDA only as an open-drain pull-down enable. Three chip-select straps let up to eight of these targets share one bus. A write-protect input blocks every array update but leaves reads working.

A bus controller sets the internal pointer with a write control byte followed by two address bytes. After that it either sends data bytes for a page write or issues a repeated start and reads. Written bytes are first collected in a page buffer. They are copied into the array only after a stop, during a self-timed write cycle that lasts WRITE_CYCLES system clocks. While that cycle runs, the target refuses to acknowledge its control byte, so the controller can poll until the write has finished.

The pointer is ADDR_W bits wide. ADDR_W = 14 gives the full 16384-byte part (0x0000 to 0x3FFF). The default of 11 keeps the elaborated array small. WRITE_CYCLES must exceed the page size, because the commit moves one buffered byte per clock.

Top module: `eeprom_i2c_target`

## Requirements
- R1: The target acknowledges a control byte only when its bits 7:4 are 1010, its bits 3:1 equal chip_sel[2:0], and no write cycle is running. For any other control byte it releases SDA for the ninth clock and ignores the bus until the next start or stop.
- R2: After a write control byte (bit 0 = 0), the next two bytes set the pointer, high byte first. Bits of the address above ADDR_W-1 are ignored.
- R3: A read control byte (bit 0 = 1) returns the byte at the pointer, MSB first. While the controller acknowledges, further bytes follow. The full pointer increments after each byte and wraps from 2**ADDR_W-1 to 0.
- R4: A read that is not preceded by an address returns data from the current pointer, which is one past the last byte read.
- R5: In a page write, each data byte goes to the buffer slot given by the low PAGE_W (6) pointer bits. Only those bits increment, so bytes past the end of a 64-byte page wrap to its start and replace the bytes buffered there earlier.
- R6: Buffered bytes reach the array only at a stop. The stop starts a write cycle of WRITE_CYCLES clocks, during which control bytes are not acknowledged.
- R7: While wp_in is high, address and data bytes are still acknowledged, but a stop starts no write cycle and the array is unchanged. Reads are unaffected.
- R8: The target changes SDA only while SCL is low. It releases SDA during the ninth clock of every byte it sends. A controller not-acknowledge ends the read, and SDA stays released.
- R9: After reset, sda_oe is low and the target waits for a start condition.
- R10: A repeated start discards bytes buffered since the last address phase. A stop that follows then starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| chip_sel | input | 3 | Strap value matched against control-byte bits 3:1 |
| wp_in | input | 1 | Write protect; high blocks array updates |

## Verification
The assertions assume a well-formed bus. SCL stays high or low for several system clocks at a time. SDA changes only while SCL is low, except at starts and stops, and the controller never issues a start or stop while the target holds SDA low. wp_in is also taken as steady across each stop. The bench drives the bus through tasks that hold every SCL phase for several clocks and change SDA only in the low phase. It changes the write-protect level only between complete transfers.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

  // Bus-side protocol phases of the target.
  typedef enum logic [2:0] {
    ST_IDLE,   // wait for a start condition
    ST_CTRL,   // shifting in the control byte
    ST_AHI,    // high address byte
    ST_ALO,    // low address byte
    ST_WDATA,  // data bytes into the page buffer
    ST_TX,     // sending read data
    ST_SKIP    // not selected, wait for start or stop
  } tgt_state_e;

  localparam logic [3:0] DEVICE_TYPE = 4'b1010;
  localparam int unsigned BIT_LAST = 9;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int unsigned PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe_q, scl_pipe_n;
  logic [PW-1:0] sda_pipe_q, sda_pipe_n;
  logic          scl_prev, sda_prev;

  always_comb begin
    scl_pipe_n = {scl_pipe_q[PW-2:0], scl_in};
    sda_pipe_n = {sda_pipe_q[PW-2:0], sda_in};
  end

  // Idle bus is high: reset the pipes to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= scl_pipe_n;
      sda_pipe_q <= sda_pipe_n;
    end
  end

  assign scl_s    = scl_pipe_q[PW-2];
  assign sda_s    = sda_pipe_q[PW-2];
  assign scl_prev = scl_pipe_q[PW-1];
  assign sda_prev = sda_pipe_q[PW-1];

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/eeprom_array_ctl.sv
module eeprom_array_ctl #(
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned PAGE_W       = 6,
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     buf_clear,
  input  logic                     buf_wr,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_data,
  input  logic [ADDR_W-PAGE_W-1:0] page_base,
  input  logic                     commit_go,
  output logic                     busy
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned PAGE  = 1 << PAGE_W;
  localparam int unsigned BW    = ADDR_W - PAGE_W;
  localparam int unsigned TW    = $clog2(WRITE_CYCLES + 1);
  localparam logic [TW-1:0] TLOAD = TW'(WRITE_CYCLES - 1);

  logic [7:0]        mem    [DEPTH];
  logic [7:0]        pbuf   [PAGE];
  logic [PAGE-1:0]   pvalid_q, pvalid_n;
  logic [BW-1:0]     base_q, base_n;
  logic              busy_q, busy_n;
  logic [TW-1:0]     timer_q, timer_n;
  logic [PAGE_W:0]   cidx_q, cidx_n;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  always_comb begin
    pvalid_n  = pvalid_q;
    base_n    = base_q;
    busy_n    = busy_q;
    timer_n   = timer_q;
    cidx_n    = cidx_q;
    mem_we    = 1'b0;
    mem_waddr = {base_q, cidx_q[PAGE_W-1:0]};
    mem_wdata = pbuf[cidx_q[PAGE_W-1:0]];
    if (busy_q) begin
      // one buffer slot per clock, then wait out the cycle
      if (!cidx_q[PAGE_W]) begin
        mem_we = pvalid_q[cidx_q[PAGE_W-1:0]];
        cidx_n = cidx_q + 1'b1;
      end
      if (timer_q == '0) begin
        busy_n   = 1'b0;
        pvalid_n = '0;
      end else begin
        timer_n = timer_q - 1'b1;
      end
    end else if (commit_go) begin
      busy_n  = 1'b1;
      timer_n = TLOAD;
      cidx_n  = '0;
    end else if (buf_clear) begin
      pvalid_n = '0;
    end else if (buf_wr) begin
      pvalid_n[buf_idx] = 1'b1;
      base_n            = page_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvalid_q <= '0;
      base_q   <= '0;
      busy_q   <= 1'b0;
      timer_q  <= '0;
      cidx_q   <= '0;
    end else begin
      pvalid_q <= pvalid_n;
      base_q   <= base_n;
      busy_q   <= busy_n;
      timer_q  <= timer_n;
      cidx_q   <= cidx_n;
    end
  end

  // Data storage carries no reset.
  always_ff @(posedge clk) begin
    if (buf_wr && !busy_q) begin
      pbuf[buf_idx] <= buf_data;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[mem_waddr] <= mem_wdata;
    end
  end

  assign rd_data = mem[rd_addr];
  assign busy    = busy_q;

  // R6
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !busy_q);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(commit_go));

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_i2c_pkg::*;
#(
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned PAGE_W       = 6,
  parameter int unsigned WRITE_CYCLES = 500000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] chip_sel,
  input  logic       wp_in
);

  localparam int unsigned BW = ADDR_W - PAGE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int = rst_pipe_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  tgt_state_e        state_q, state_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [7:0]        sh_q, sh_n;
  logic              oe_q, oe_n;
  logic              ack_q, ack_n;     // this byte was acknowledged by us
  logic              cack_q, cack_n;   // controller acknowledged read byte
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [7:0]        hi_q, hi_n;
  logic              pend_q, pend_n;

  logic              busy, buf_clear, buf_wr, commit_go, load, hit, active;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] ptr_in_page;

  eeprom_array_ctl #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_int),
    .rd_addr  (ptr_q),
    .rd_data  (rd_data),
    .buf_clear(buf_clear),
    .buf_wr   (buf_wr),
    .buf_idx  (ptr_q[PAGE_W-1:0]),
    .buf_data (sh_q),
    .page_base(ptr_q[ADDR_W-1:PAGE_W]),
    .commit_go(commit_go),
    .busy     (busy)
  );

  assign active      = (state_q != ST_IDLE) && (state_q != ST_SKIP);
  assign hit         = (sh_q[7:4] == DEVICE_TYPE) && (sh_q[3:1] == chip_sel) && !busy;
  assign ptr_in_page = {ptr_q[ADDR_W-1:PAGE_W], PAGE_W'(ptr_q[PAGE_W-1:0] + 1'b1)};

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    oe_n      = oe_q;
    ack_n     = ack_q;
    cack_n    = cack_q;
    ptr_n     = ptr_q;
    hi_n      = hi_q;
    pend_n    = pend_q;
    buf_clear = 1'b0;
    buf_wr    = 1'b0;
    commit_go = 1'b0;
    load      = 1'b0;
    if (stop_det) begin
      state_n   = ST_IDLE;
      cnt_n     = '0;
      oe_n      = 1'b0;
      pend_n    = 1'b0;
      commit_go = pend_q && !wp_in && !busy;
    end else if (start_det) begin
      state_n = ST_CTRL;
      cnt_n   = '0;
      oe_n    = 1'b0;
      pend_n  = 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (cnt_q < 4'd8) begin
          if (state_q != ST_TX) sh_n = {sh_q[6:0], sda_s};
        end else if (state_q == ST_TX) begin
          cack_n = !sda_s;
        end
        cnt_n = cnt_q + 1'b1;
      end else if (scl_fall) begin
        if (cnt_q == 4'd8) begin
          // start of the ninth clock: acknowledge slot
          oe_n  = 1'b0;
          ack_n = 1'b0;
          case (state_q)
            ST_CTRL: begin
              ack_n = hit;
              oe_n  = hit;
            end
            ST_AHI: begin
              ack_n = 1'b1;
              oe_n  = 1'b1;
              hi_n  = sh_q;
            end
            ST_ALO: begin
              ack_n     = 1'b1;
              oe_n      = 1'b1;
              ptr_n     = ADDR_W'({hi_q, sh_q});
              buf_clear = 1'b1;
            end
            ST_WDATA: begin
              ack_n  = 1'b1;
              oe_n   = 1'b1;
              buf_wr = 1'b1;
              ptr_n  = ptr_in_page;
              pend_n = 1'b1;
            end
            default: ;
          endcase
        end else if (cnt_q == 4'(BIT_LAST)) begin
          cnt_n = '0;
          oe_n  = 1'b0;
          case (state_q)
            ST_CTRL: begin
              if (!ack_q)        state_n = ST_SKIP;
              else if (sh_q[0])  load    = 1'b1;
              else               state_n = ST_AHI;
            end
            ST_AHI: state_n = ST_ALO;
            ST_ALO: state_n = ST_WDATA;
            ST_TX: begin
              if (cack_q) load    = 1'b1;
              else        state_n = ST_SKIP;
            end
            default: ;
          endcase
          if (load) begin
            state_n = ST_TX;
            sh_n    = rd_data;
            ptr_n   = ptr_q + 1'b1;
            oe_n    = !rd_data[7];
          end
        end else if (state_q == ST_TX && cnt_q != 4'd0) begin
          oe_n = !sh_q[3'(4'd7 - cnt_q)];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b0;
      cack_q  <= 1'b0;
      ptr_q   <= '0;
      hi_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      oe_q    <= oe_n;
      ack_q   <= ack_n;
      cack_q  <= cack_n;
      ptr_q   <= ptr_n;
      hi_q    <= hi_n;
      pend_q  <= pend_n;
    end
  end

  assign sda_oe = oe_q;

  // R8
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (oe_q != $past(oe_q)) |-> !scl_s);

  // R8
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (state_q == ST_SKIP) |-> !oe_q);

  // R6
  no_addr_busy_chk: assert property (@(posedge clk) disable iff (!rst_int)
    busy |-> (state_q != ST_AHI && state_q != ST_ALO && state_q != ST_WDATA));

  // R7
  wp_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(busy) |-> !$past(wp_in));

  // R1
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_int)
    cnt_q <= 4'(BIT_LAST));

endmodule

// File: tb/eeprom_i2c_target_bench.sv
module eeprom_i2c_target_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int AW         = 11;
  localparam int DEPTH      = 1 << AW;
  localparam int WCYC       = 300;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk, rst_n, scl, ctl_low, wp;
  logic sda_oe, sda_line;
  int   nchk, nfail;
  logic [7:0] ref_mem [DEPTH];
  int   bench_ptr;
  logic [7:0] exp_v[$];
  string      exp_r[$];
  logic [7:0] got_q[$];

  assign sda_line = ~(ctl_low | sda_oe);

  eeprom_i2c_target #(
    .ADDR_W      (AW),
    .PAGE_W      (6),
    .WRITE_CYCLES(WCYC),
    .SYNC_STAGES (2)
  ) u_eeprom_i2c_target (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_in  (scl),
    .sda_in  (sda_line),
    .sda_oe  (sda_oe),
    .chip_sel(STRAP),
    .wp_in   (wp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() != 0 && exp_v.size() != 0) begin
        logic [7:0] g, e;
        string r;
        g = got_q.pop_front();
        e = exp_v.pop_front();
        r = exp_r.pop_front();
        check(g === e, r, "read byte", int'(g), int'(e));
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got running expected done");
    finish_run();
  end

  task automatic i2c_start();
    ctl_low = 1'b0; tick(Q);
    scl = 1'b1;     tick(Q);
    ctl_low = 1'b1; tick(Q);
    scl = 1'b0;     tick(Q);
  endtask

  task automatic i2c_stop();
    ctl_low = 1'b1; tick(Q);
    scl = 1'b1;     tick(Q);
    ctl_low = 1'b0; tick(Q);
  endtask

  task automatic send_bit(input bit b);
    ctl_low = !b; tick(Q);
    scl = 1'b1;   tick(2*Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic recv_bit(output bit b);
    ctl_low = 1'b0; tick(Q);
    scl = 1'b1;     tick(Q);
    b = sda_line;   tick(Q);
    scl = 1'b0;     tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit give_ack);
    logic [7:0] d;
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    got_q.push_back(d);
    if (give_ack) begin
      send_bit(1'b0);
    end else begin
      ctl_low = 1'b0; tick(Q);
      scl = 1'b1;     tick(Q);
      // R8: target releases SDA in the acknowledge slot
      check(sda_oe == 1'b0, "R8", "sda_oe in nack slot", int'(sda_oe), 0);
      tick(Q);
      scl = 1'b0;     tick(Q);
    end
  endtask

  function automatic logic [7:0] ctrl(input logic [2:0] cs, input bit rd);
    return {4'b1010, cs, rd};
  endfunction

  task automatic write_bytes(input int addr, input logic [7:0] d[$], input string req);
    bit a;
    int p;
    i2c_start();
    send_byte(ctrl(STRAP, 1'b0), a); check(a, "R1", "ctrl write ack", a, 1);
    send_byte(8'(addr >> 8), a);     check(a, "R2", "addr high ack", a, 1);
    send_byte(8'(addr), a);          check(a, "R2", "addr low ack", a, 1);
    p = addr & (DEPTH - 1);
    foreach (d[i]) begin
      send_byte(d[i], a);
      check(a, req, "data ack", a, 1);
      if (!wp) ref_mem[p] = d[i];
      p = (p & ~63) | ((p + 1) & 63);
    end
    bench_ptr = p;
    i2c_stop();
  endtask

  task automatic poll_ready(input bit expect_busy, input string req);
    bit a;
    int n;
    n = 0;
    a = 1'b0;
    while (!a && n < 20) begin
      i2c_start();
      send_byte(ctrl(STRAP, 1'b0), a);
      n++;
    end
    i2c_stop();
    check(a, req, "poll eventually acked", a, 1);
    if (expect_busy) check(n > 1, req, "first poll refused", n, 2);
    else             check(n == 1, req, "first poll acked", n, 1);
  endtask

  task automatic read_raw(input logic [7:0] hi, input logic [7:0] lo,
                          input int eff, input int n, input string req);
    bit a;
    for (int i = 0; i < n; i++) begin
      exp_v.push_back(ref_mem[(eff + i) & (DEPTH - 1)]);
      exp_r.push_back(req);
    end
    i2c_start();
    send_byte(ctrl(STRAP, 1'b0), a); check(a, "R1", "ctrl write ack", a, 1);
    send_byte(hi, a);                check(a, "R2", "addr high ack", a, 1);
    send_byte(lo, a);                check(a, "R2", "addr low ack", a, 1);
    i2c_start();
    send_byte(ctrl(STRAP, 1'b1), a); check(a, "R1", "ctrl read ack", a, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
    i2c_stop();
    bench_ptr = (eff + n) & (DEPTH - 1);
    check(sda_oe == 1'b0, "R8", "sda released after read", int'(sda_oe), 0);
  endtask

  task automatic read_rand(input int addr, input int n, input string req);
    read_raw(8'(addr >> 8), 8'(addr), addr & (DEPTH - 1), n, req);
  endtask

  task automatic read_cur(input int n, input string req);
    bit a;
    for (int i = 0; i < n; i++) begin
      exp_v.push_back(ref_mem[(bench_ptr + i) & (DEPTH - 1)]);
      exp_r.push_back(req);
    end
    i2c_start();
    send_byte(ctrl(STRAP, 1'b1), a); check(a, req, "ctrl read ack", a, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
    i2c_stop();
    bench_ptr = (bench_ptr + n) & (DEPTH - 1);
  endtask

  initial begin
    logic [7:0] d[$];
    bit a;
    nchk = 0;
    nfail = 0;
    bench_ptr = 0;
    rst_n = 1'b0;
    scl = 1'b1;
    ctl_low = 1'b0;
    wp = 1'b0;
    tick(5);
    check(sda_oe == 1'b0, "R9", "sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe == 1'b0, "R9", "sda_oe after reset", int'(sda_oe), 0);

    // single byte write, then acknowledge polling
    d = '{8'hA5};
    write_bytes(16'h0010, d, "R6");
    poll_ready(1'b1, "R6");
    read_rand(16'h0010, 1, "R3");

    // page write that wraps within its page
    d = '{8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16};
    write_bytes(16'h003C, d, "R5");
    poll_ready(1'b1, "R6");
    read_rand(16'h003C, 4, "R5");
    read_rand(16'h0000, 2, "R5");

    // 66 bytes into one page: first two slots overwritten
    d.delete();
    for (int i = 0; i < 66; i++) d.push_back(8'(i + 8'h40));
    write_bytes(16'h0080, d, "R5");
    poll_ready(1'b1, "R6");
    read_rand(16'h0080, 3, "R5");

    // sequential read across a page edge, then current-address read
    d.delete();
    for (int i = 0; i < 64; i++) d.push_back(8'(8'hC3 ^ i));
    write_bytes(16'h00C0, d, "R5");
    poll_ready(1'b1, "R6");
    read_rand(16'h00BC, 8, "R3");
    read_cur(2, "R4");

    // top page, then a read that wraps to address zero
    d.delete();
    for (int i = 0; i < 64; i++) d.push_back(8'(8'h9A + 3 * i));
    write_bytes(16'h07C0, d, "R5");
    poll_ready(1'b1, "R6");
    read_rand(DEPTH - 2, 4, "R3");

    // unused high address bits are ignored
    read_raw(8'hF8, 8'h10, 16'h0010, 1, "R2");

    // write protect: acked, nothing committed, no busy window
    wp = 1'b1;
    d = '{8'h3C};
    write_bytes(16'h0010, d, "R7");
    poll_ready(1'b0, "R7");
    read_rand(16'h0010, 1, "R7");
    wp = 1'b0;

    // wrong strap and wrong device type are refused
    i2c_start();
    send_byte(ctrl(STRAP ^ 3'b001, 1'b0), a);
    check(!a, "R1", "strap mismatch ack", a, 0);
    i2c_stop();
    i2c_start();
    send_byte({4'b1011, STRAP, 1'b1}, a);
    check(!a, "R1", "type mismatch ack", a, 0);
    i2c_stop();
    check(sda_oe == 1'b0, "R1", "sda idle after refusal", int'(sda_oe), 0);

    // repeated start drops buffered bytes
    i2c_start();
    send_byte(ctrl(STRAP, 1'b0), a);
    send_byte(8'h00, a);
    send_byte(8'h10, a);
    send_byte(8'h77, a);
    check(a, "R10", "data ack before restart", a, 1);
    i2c_start();
    send_byte(ctrl(STRAP, 1'b0), a);
    check(a, "R10", "ctrl ack after restart", a, 1);
    i2c_stop();
    poll_ready(1'b0, "R10");
    read_rand(16'h0010, 1, "R10");

    tick(20);
    check(exp_v.size() == 0, "R3", "pending expected bytes", exp_v.size(), 0);
    finish_run();
  end

endmodule